// File: doc/BRIEF.md
# SD Host Buffer-to-Memory DMA Engine

This block moves one complete multi-block transfer between the SD host's data buffer and system memory. Software programs a direction, an address step mode and a 64-bit start address, then starts the engine. In the card-to-memory direction the engine takes words from the buffer and writes them to memory. In the memory-to-card direction it reads words from memory and hands them to the buffer. The engine moves one word at a time. The transfer length comes from the host's shared block size and block count.

Completion and error are reported in two flag words. The two directions have separate completion bits. The card-to-memory direction has two completion bits. The first rises when the last word has left the buffer. The second rises only when memory has acknowledged the last write, and software should use this second bit to decide that the data has fully landed. Software clears both flag words by writing zero to them before a start. Any nonzero error word means the transfer failed. The engine only accepts a start while the DMA enable bit of the extended-mode register is set; when that bit is clear, the buffer is left to programmed I/O.

Register word indices on `reg_addr_i`: 0 extended mode, 1 mode, 2 control, 3 channel reset, 4 completion, 5 error, 6 address low, 7 address high. Reads of control and channel reset return zero.

Top module: `sdma_top`

## Requirements
- R1: A write of control bit 0 starts a transfer only while extended-mode bit 1 is set. Otherwise it causes no memory request, takes no buffer word and sets no flag.
- R2: Mode bit 16 set selects card-to-memory: buffer words are taken and written to memory (`mem_we_o`=1). With bit 16 clear, memory is read (`mem_we_o`=0) and the words are offered to the buffer in order.
- R3: The first word uses address {address high, address low}. When mode bit 0 is set, each later word uses an address 4 bytes higher. When mode bit 0 is clear, every word uses the start address.
- R4: The transfer moves (block size in bytes × block count) / 4 words. A zero length completes at start with no traffic and sets the completion bits of its direction.
- R5: In card-to-memory transfers, completion bit 17 sets when the last word is taken from the buffer. Completion bit 20 sets only after memory acknowledges the last write, and bit 17 is observable before bit 20.
- R6: In memory-to-card transfers, completion bit 16 sets when the buffer accepts the last word.
- R7: A start whose address has any of its low 4 bits set raises error bit 17 (card-to-memory) or error bit 16 (memory-to-card) at once. It issues no memory request and takes no buffer word.
- R8: A software write to the completion or error word replaces its defined bits, so writing zero clears it.
- R9: Channel reset bit 9 aborts an active card-to-memory transfer, and bit 8 aborts an active memory-to-card transfer. An aborted transfer issues no further traffic and sets no completion bit. A reset bit for the other direction has no effect.
- R10: A start while a transfer is active is ignored, and the active transfer keeps its address and length.
- R11: After reset, all registers read zero and no memory request, buffer take or buffer offer is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| blk_size_i | input | SIZE_W | Block size in bytes from host |
| blk_cnt_i | input | CNT_W | Block count from host |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr_o | output | 64 | Memory byte address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_ready_i | input | 1 | Memory accepts request |
| mem_wack_i | input | 1 | Memory write acknowledge |
| mem_rvalid_i | input | 1 | Memory read data valid |
| mem_rdata_i | input | DATA_W | Memory read data |
| buf_rd_valid_i | input | 1 | Buffer offers a word |
| buf_rd_data_i | input | DATA_W | Word from buffer |
| buf_rd_ready_o | output | 1 | Engine takes buffer word |
| buf_wr_valid_o | output | 1 | Engine offers word to buffer |
| buf_wr_data_o | output | DATA_W | Word to buffer |
| buf_wr_ready_i | input | 1 | Buffer accepts word |

## Verification
The main transfer is tried with multi-block card-to-memory transfers, single-block memory-to-card transfers, transfers with a fixed address, transfers with a nonzero high address, zero-length transfers and misaligned addresses. Together these separate direction decoding, address stepping and length arithmetic from the flag-setting paths. The memory toggles its ready signal and acknowledges writes late. This exposes the gap between the two read-completion bits and any address that drifts while a request is stalled. Directed cases stall the buffer to test channel aborts, starts while busy, and starts while the enable bit is clear.

// File: rtl/sdma_pkg.sv
`timescale 1ns/1ps
package sdma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_BUF, ST_RD_MEM, ST_RD_ACK, ST_WR_MEM, ST_WR_RSP, ST_WR_BUF
  } st_e;

  localparam logic [2:0] RA_EXT   = 3'd0;
  localparam logic [2:0] RA_MODE  = 3'd1;
  localparam logic [2:0] RA_CTL   = 3'd2;
  localparam logic [2:0] RA_CHRST = 3'd3;
  localparam logic [2:0] RA_DONE  = 3'd4;
  localparam logic [2:0] RA_ERR   = 3'd5;
  localparam logic [2:0] RA_LO    = 3'd6;
  localparam logic [2:0] RA_HI    = 3'd7;

  localparam int B_EXT_EN   = 1;
  localparam int B_DIR_RD   = 16;
  localparam int B_INC      = 0;
  localparam int B_GO       = 0;
  localparam int B_RST_WR   = 8;
  localparam int B_RST_RD   = 9;
  localparam int B_DONE_WR  = 16;
  localparam int B_DONE_RD  = 17;
  localparam int B_DONE_RD2 = 20;
  localparam int B_ERR_WR   = 16;
  localparam int B_ERR_RD   = 17;

  localparam logic [31:0] EXT_MASK  = 32'h0000_0002;
  localparam logic [31:0] MODE_MASK = 32'h0001_0001;
  localparam logic [31:0] DONE_MASK = 32'h0013_0000;
  localparam logic [31:0] ERR_MASK  = 32'h0003_0000;

  localparam int ALIGN_BITS = 4;
endpackage

// File: rtl/sdma_regs.sv
`timescale 1ns/1ps
module sdma_regs
  import sdma_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [2:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic        set_done_wr_i,
  input  logic        set_done_rd_i,
  input  logic        set_done_rd2_i,
  input  logic        set_err_wr_i,
  input  logic        set_err_rd_i,
  output logic        start_o,
  output logic        dir_rd_o,
  output logic        inc_o,
  output logic [63:0] base_o,
  output logic        rst_wr_o,
  output logic        rst_rd_o
);
  logic [31:0] ext_q, mode_q, done_q, err_q, lo_q, hi_q;
  logic [31:0] done_set, err_set;

  always_comb begin
    done_set = '0;
    done_set[B_DONE_WR]  = set_done_wr_i;
    done_set[B_DONE_RD]  = set_done_rd_i;
    done_set[B_DONE_RD2] = set_done_rd2_i;
    err_set = '0;
    err_set[B_ERR_WR] = set_err_wr_i;
    err_set[B_ERR_RD] = set_err_rd_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_q <= '0; mode_q <= '0; done_q <= '0;
      err_q <= '0; lo_q <= '0; hi_q <= '0;
    end else begin
      if (we_i && addr_i == RA_EXT)  ext_q  <= wdata_i & EXT_MASK;
      if (we_i && addr_i == RA_MODE) mode_q <= wdata_i & MODE_MASK;
      if (we_i && addr_i == RA_LO)   lo_q   <= wdata_i;
      if (we_i && addr_i == RA_HI)   hi_q   <= wdata_i;
      // hardware set wins over a same-cycle software write
      done_q <= ((we_i && addr_i == RA_DONE) ? (wdata_i & DONE_MASK) : done_q) | done_set;
      err_q  <= ((we_i && addr_i == RA_ERR)  ? (wdata_i & ERR_MASK)  : err_q)  | err_set;
    end
  end

  always_comb begin
    unique case (addr_i)
      RA_EXT:  rdata_o = ext_q;
      RA_MODE: rdata_o = mode_q;
      RA_DONE: rdata_o = done_q;
      RA_ERR:  rdata_o = err_q;
      RA_LO:   rdata_o = lo_q;
      RA_HI:   rdata_o = hi_q;
      default: rdata_o = '0;
    endcase
  end

  assign start_o  = we_i && addr_i == RA_CTL && wdata_i[B_GO] && ext_q[B_EXT_EN];
  assign rst_wr_o = we_i && addr_i == RA_CHRST && wdata_i[B_RST_WR];
  assign rst_rd_o = we_i && addr_i == RA_CHRST && wdata_i[B_RST_RD];
  assign dir_rd_o = mode_q[B_DIR_RD];
  assign inc_o    = mode_q[B_INC];
  assign base_o   = {hi_q, lo_q};

  a_r8_sw_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == RA_DONE && wdata_i == '0 &&
     !set_done_wr_i && !set_done_rd_i && !set_done_rd2_i) |=> (rdata_o == '0 || addr_i != RA_DONE) && done_q == '0);
endmodule

// File: rtl/sdma_engine.sv
`timescale 1ns/1ps
module sdma_engine
  import sdma_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 26
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              dir_rd_i,
  input  logic              inc_i,
  input  logic [63:0]       base_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              abort_rd_i,
  input  logic              abort_wr_i,
  output logic              set_done_wr_o,
  output logic              set_done_rd_o,
  output logic              set_done_rd2_o,
  output logic              set_err_wr_o,
  output logic              set_err_rd_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [63:0]       mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ready_i,
  input  logic              mem_wack_i,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              buf_rd_valid_i,
  input  logic [DATA_W-1:0] buf_rd_data_i,
  output logic              buf_rd_ready_o,
  output logic              buf_wr_valid_o,
  output logic [DATA_W-1:0] buf_wr_data_o,
  input  logic              buf_wr_ready_i
);
  localparam int STEP = DATA_W / 8;

  st_e               st_q, st_d;
  logic [LEN_W-1:0]  cnt_q;
  logic [63:0]       ptr_q;
  logic [DATA_W-1:0] dat_q;
  logic              rd_buf_done_q;

  logic idle, in_rd, in_wr, misal, launch, len_zero, abort, last;
  logic buf_take, mem_wdone, wr_hand;

  assign idle     = st_q == ST_IDLE;
  assign in_rd    = st_q inside {ST_RD_BUF, ST_RD_MEM, ST_RD_ACK};
  assign in_wr    = st_q inside {ST_WR_MEM, ST_WR_RSP, ST_WR_BUF};
  assign misal    = |base_i[ALIGN_BITS-1:0];
  assign launch   = start_i && idle;
  assign len_zero = len_i == '0;
  assign abort    = (abort_rd_i && in_rd) || (abort_wr_i && in_wr);
  assign last     = cnt_q == LEN_W'(1);
  assign buf_take = st_q == ST_RD_BUF && buf_rd_valid_i;
  assign mem_wdone = st_q == ST_RD_ACK && mem_wack_i;
  assign wr_hand  = st_q == ST_WR_BUF && buf_wr_ready_i;

  assign set_err_rd_o   = launch && misal && dir_rd_i;
  assign set_err_wr_o   = launch && misal && !dir_rd_i;
  assign set_done_rd_o  = (buf_take && last && !abort) || (launch && !misal && len_zero && dir_rd_i);
  assign set_done_rd2_o = (mem_wdone && last && !abort) || (launch && !misal && len_zero && dir_rd_i);
  assign set_done_wr_o  = (wr_hand && last && !abort) || (launch && !misal && len_zero && !dir_rd_i);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (launch && !misal && !len_zero) st_d = dir_rd_i ? ST_RD_BUF : ST_WR_MEM;
      ST_RD_BUF: if (buf_rd_valid_i) st_d = ST_RD_MEM;
      ST_RD_MEM: if (mem_ready_i) st_d = ST_RD_ACK;
      ST_RD_ACK: if (mem_wack_i) st_d = last ? ST_IDLE : ST_RD_BUF;
      ST_WR_MEM: if (mem_ready_i) st_d = ST_WR_RSP;
      ST_WR_RSP: if (mem_rvalid_i) st_d = ST_WR_BUF;
      ST_WR_BUF: if (buf_wr_ready_i) st_d = last ? ST_IDLE : ST_WR_MEM;
      default:   st_d = ST_IDLE;
    endcase
    if (abort) st_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
      cnt_q <= '0;
      ptr_q <= '0;
      dat_q <= '0;
      rd_buf_done_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (launch) begin
        cnt_q <= len_i;
        ptr_q <= base_i;
        rd_buf_done_q <= 1'b0;
      end
      if (buf_take) begin
        dat_q <= buf_rd_data_i;
        if (last) rd_buf_done_q <= 1'b1;
      end
      if (st_q == ST_WR_RSP && mem_rvalid_i) dat_q <= mem_rdata_i;
      if (mem_wdone || wr_hand) begin
        cnt_q <= cnt_q - LEN_W'(1);
        ptr_q <= ptr_q + (inc_i ? 64'(STEP) : 64'd0);
      end
    end
  end

  assign mem_req_o      = st_q == ST_RD_MEM || st_q == ST_WR_MEM;
  assign mem_we_o       = st_q == ST_RD_MEM;
  assign mem_addr_o     = ptr_q;
  assign mem_wdata_o    = dat_q;
  assign buf_rd_ready_o = st_q == ST_RD_BUF;
  assign buf_wr_valid_o = st_q == ST_WR_BUF;
  assign buf_wr_data_o  = dat_q;

  a_r7_misal_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (launch && misal) |=> (!mem_req_o && !buf_rd_ready_o && !buf_wr_valid_o));
  a_r3_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i && !abort) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));
  a_r9_abort_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort |=> (!mem_req_o && !buf_rd_ready_o && !buf_wr_valid_o));
  a_r5_rd2_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_done_rd2_o && st_q == ST_RD_ACK) |-> rd_buf_done_q);
  a_r10_busy_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !idle && !abort && !mem_wdone && !wr_hand) |=> ($stable(cnt_q) && $stable(ptr_q)));
endmodule

// File: rtl/sdma_top.sv
`timescale 1ns/1ps
module sdma_top
  import sdma_pkg::*;
#(
  parameter int SIZE_W = 10,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic [SIZE_W-1:0] blk_size_i,
  input  logic [CNT_W-1:0]  blk_cnt_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [63:0]       mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ready_i,
  input  logic              mem_wack_i,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              buf_rd_valid_i,
  input  logic [DATA_W-1:0] buf_rd_data_i,
  output logic              buf_rd_ready_o,
  output logic              buf_wr_valid_o,
  output logic [DATA_W-1:0] buf_wr_data_o,
  input  logic              buf_wr_ready_i
);
  localparam int LEN_W   = SIZE_W + CNT_W;
  localparam int BYTE_SH = $clog2(DATA_W / 8);

  logic [LEN_W-1:0] bytes_w, words_w;
  logic start, dir_rd, inc, rst_wr, rst_rd;
  logic [63:0] base;
  logic s_done_wr, s_done_rd, s_done_rd2, s_err_wr, s_err_rd;

  assign bytes_w = LEN_W'(blk_size_i) * LEN_W'(blk_cnt_i);
  assign words_w = bytes_w >> BYTE_SH;

  sdma_regs u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .set_done_wr_i(s_done_wr), .set_done_rd_i(s_done_rd), .set_done_rd2_i(s_done_rd2),
    .set_err_wr_i(s_err_wr), .set_err_rd_i(s_err_rd),
    .start_o(start), .dir_rd_o(dir_rd), .inc_o(inc), .base_o(base),
    .rst_wr_o(rst_wr), .rst_rd_o(rst_rd)
  );

  sdma_engine #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_eng (
    .clk_i, .rst_ni,
    .start_i(start), .dir_rd_i(dir_rd), .inc_i(inc), .base_i(base), .len_i(words_w),
    .abort_rd_i(rst_rd), .abort_wr_i(rst_wr),
    .set_done_wr_o(s_done_wr), .set_done_rd_o(s_done_rd), .set_done_rd2_o(s_done_rd2),
    .set_err_wr_o(s_err_wr), .set_err_rd_o(s_err_rd),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .mem_ready_i, .mem_wack_i, .mem_rvalid_i, .mem_rdata_i,
    .buf_rd_valid_i, .buf_rd_data_i, .buf_rd_ready_o,
    .buf_wr_valid_o, .buf_wr_data_o, .buf_wr_ready_i
  );
endmodule

// File: tb/sim_sdma_top.sv
`timescale 1ns/1ps
module sim_sdma_top;
  typedef struct packed {
    logic        rd;
    logic        inc;
    logic [9:0]  bsz;
    logic [15:0] bcnt;
    logic [31:0] lo;
    logic [31:0] hi;
    logic [31:0] done;
    logic [31:0] err;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 10'd8,  16'd2, 32'h10, 32'h0, 32'h0012_0000, 32'h0},          // R2 R4 read multi-block
    '{1'b0, 1'b1, 10'd16, 16'd1, 32'h40, 32'h1, 32'h0001_0000, 32'h0},          // R6 write, high addr
    '{1'b1, 1'b1, 10'd4,  16'd1, 32'h14, 32'h0, 32'h0,         32'h0002_0000},  // R7 read misaligned
    '{1'b0, 1'b1, 10'd4,  16'd1, 32'h48, 32'h0, 32'h0,         32'h0001_0000},  // R7 write misaligned
    '{1'b1, 1'b0, 10'd4,  16'd3, 32'h80, 32'h2, 32'h0012_0000, 32'h0},          // R3 fixed addr read
    '{1'b0, 1'b0, 10'd4,  16'd2, 32'h20, 32'h0, 32'h0001_0000, 32'h0},          // R3 fixed addr write
    '{1'b1, 1'b1, 10'd4,  16'd0, 32'h30, 32'h0, 32'h0012_0000, 32'h0}           // R4 zero length
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [9:0]  blk_size = '0;
  logic [15:0] blk_cnt = '0;
  logic        mem_req, mem_we;
  logic [63:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_ready = 1'b1, mem_wack = 1'b0, mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        buf_rd_valid = 1'b0;
  logic [31:0] buf_rd_data = '0;
  logic        buf_rd_ready, buf_wr_valid;
  logic [31:0] buf_wr_data;
  logic        buf_wr_ready = 1'b1;

  sdma_top u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .blk_size_i(blk_size), .blk_cnt_i(blk_cnt),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ready_i(mem_ready), .mem_wack_i(mem_wack), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .buf_rd_valid_i(buf_rd_valid), .buf_rd_data_i(buf_rd_data), .buf_rd_ready_o(buf_rd_ready),
    .buf_wr_valid_o(buf_wr_valid), .buf_wr_data_o(buf_wr_data), .buf_wr_ready_i(buf_wr_ready)
  );

  int total = 0, bad = 0;
  int req_count = 0, src_idx = 0, sink_idx = 0, addr_bad = 0;
  int wack_dly = 0, rd_dly = 0;
  logic src_en = 1'b0;
  logic seen_rd_first = 1'b0;
  logic [31:0] exp_hi = '0;
  logic [31:0] rd_pending = '0;
  logic [31:0] mem [64];
  logic [31:0] sink [64];

  // memory and buffer model: drive inputs, then resolve the handshake of the next edge
  initial begin
    for (int j = 0; j < 64; j++) mem[j] = 32'h5A00_0000 + 32'(j);
    forever begin
      @(negedge clk);
      if (wack_dly > 0) begin wack_dly--; mem_wack = (wack_dly == 0); end else mem_wack = 1'b0;
      if (rd_dly > 0) begin
        rd_dly--;
        mem_rvalid = (rd_dly == 0);
        mem_rdata = rd_pending;
      end else mem_rvalid = 1'b0;
      mem_ready = ~mem_ready;
      buf_rd_valid = src_en;
      buf_rd_data = 32'hC0DE_0000 + 32'(src_idx);
      if (rst_n && mem_req && mem_ready) begin
        req_count++;
        if (mem_addr[63:32] != exp_hi) addr_bad++;
        if (mem_we) begin mem[mem_addr[7:2]] = mem_wdata; wack_dly = 3; end
        else begin rd_pending = mem[mem_addr[7:2]]; rd_dly = 2; end
      end
      if (rst_n && buf_rd_ready && buf_rd_valid) src_idx++;
      if (rst_n && buf_wr_valid && buf_wr_ready) begin sink[sink_idx[5:0]] = buf_wr_data; sink_idx++; end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_poll(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      reg_addr = 3'd4;
      #1 if (reg_rdata[17] && !reg_rdata[20]) seen_rd_first = 1'b1;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d, e;
    int r0, s0, k0, words, base_idx;
    logic ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    for (int a = 0; a < 8; a++) begin
      reg_rd(3'(a), d);
      chk(d == '0, "R11 register reads zero", d, 32'h0);
    end
    chk(!mem_req, "R11 no memory request", {31'b0, mem_req}, 32'h0);
    chk(!buf_rd_ready, "R11 no buffer take", {31'b0, buf_rd_ready}, 32'h0);
    chk(!buf_wr_valid, "R11 no buffer offer", {31'b0, buf_wr_valid}, 32'h0);

    // R1 start ignored while enable clear
    src_en = 1'b1;
    blk_size = 10'd4; blk_cnt = 16'd1;
    reg_wr(3'd1, 32'h0001_0001);
    reg_wr(3'd6, 32'h100);
    r0 = req_count; s0 = src_idx;
    reg_wr(3'd2, 32'h1);
    wait_poll(30);
    chk(req_count == r0, "R1 no memory traffic when disabled", 32'(req_count - r0), 32'h0);
    chk(src_idx == s0, "R1 no buffer take when disabled", 32'(src_idx - s0), 32'h0);
    reg_rd(3'd4, d);
    chk(d == '0, "R1 no completion when disabled", d, 32'h0);

    reg_wr(3'd0, 32'h2);

    // vector table: R2 R3 R4 R5 R6 R7
    for (int v = 0; v < NV; v++) begin
      vec_t t;
      t = VECS[v];
      words = (int'(t.bsz) * int'(t.bcnt)) / 4;
      blk_size = t.bsz; blk_cnt = t.bcnt; exp_hi = t.hi;
      reg_wr(3'd4, 32'h0);
      reg_wr(3'd5, 32'h0);
      reg_wr(3'd1, {15'b0, t.rd, 15'b0, t.inc});
      reg_wr(3'd6, t.lo);
      reg_wr(3'd7, t.hi);
      seen_rd_first = 1'b0;
      r0 = req_count; s0 = src_idx; k0 = sink_idx;
      reg_wr(3'd2, 32'h1);
      wait_poll(150);
      reg_rd(3'd4, d);
      reg_rd(3'd5, e);
      chk(d == t.done, $sformatf("R4 R5 R6 completion word vec %0d", v), d, t.done);
      chk(e == t.err, $sformatf("R7 error word vec %0d", v), e, t.err);
      chk(req_count - r0 == ((t.err != 0) ? 0 : words), $sformatf("R4 R7 request count vec %0d", v),
          32'(req_count - r0), 32'((t.err != 0) ? 0 : words));
      base_idx = int'(t.lo[7:2]);
      ok = 1'b1;
      if (t.err == 0 && words > 0) begin
        if (t.rd && t.inc) begin
          for (int i = 0; i < words; i++)
            if (mem[(base_idx + i) % 64] != 32'hC0DE_0000 + 32'(s0 + i)) ok = 1'b0;
        end else if (t.rd) begin
          if (mem[base_idx] != 32'hC0DE_0000 + 32'(s0 + words - 1)) ok = 1'b0;
        end else begin
          for (int i = 0; i < words; i++)
            if (sink[(k0 + i) % 64] != 32'h5A00_0000 + 32'(base_idx + (t.inc ? i : 0))) ok = 1'b0;
        end
      end else if (src_idx != s0 || sink_idx != k0) ok = 1'b0;
      chk(ok, $sformatf("R2 R3 data placement vec %0d", v), {31'b0, ok}, 32'h1);
      if (v == 0) chk(seen_rd_first, "R5 bit17 seen before bit20", {31'b0, seen_rd_first}, 32'h1);
    end

    // R8 software replace and clear
    reg_wr(3'd4, 32'h0);
    reg_rd(3'd4, d);
    chk(d == '0, "R8 completion cleared by zero write", d, 32'h0);
    reg_wr(3'd5, 32'h0003_0000);
    reg_rd(3'd5, d);
    chk(d == 32'h0003_0000, "R8 error word replaced", d, 32'h0003_0000);
    reg_wr(3'd5, 32'h0);
    reg_rd(3'd5, d);
    chk(d == '0, "R8 error word cleared", d, 32'h0);

    // R9 channel reset
    src_en = 1'b0;
    exp_hi = '0;
    blk_size = 10'd4; blk_cnt = 16'd2;
    reg_wr(3'd1, 32'h0001_0001);
    reg_wr(3'd6, 32'h60);
    reg_wr(3'd7, 32'h0);
    reg_wr(3'd2, 32'h1);
    wait_poll(4);
    chk(buf_rd_ready, "R2 read waits on buffer", {31'b0, buf_rd_ready}, 32'h1);
    reg_wr(3'd3, 32'h100);
    wait_poll(2);
    chk(buf_rd_ready, "R9 write-channel reset leaves read active", {31'b0, buf_rd_ready}, 32'h1);
    reg_wr(3'd3, 32'h200);
    wait_poll(2);
    chk(!buf_rd_ready, "R9 read-channel reset aborts", {31'b0, buf_rd_ready}, 32'h0);
    r0 = req_count;
    src_en = 1'b1;
    wait_poll(40);
    chk(req_count == r0, "R9 no traffic after abort", 32'(req_count - r0), 32'h0);
    reg_rd(3'd4, d);
    chk(d == '0, "R9 no completion after abort", d, 32'h0);

    // R10 start while busy
    src_en = 1'b0;
    reg_wr(3'd6, 32'h60);
    s0 = src_idx;
    reg_wr(3'd2, 32'h1);
    wait_poll(3);
    reg_wr(3'd6, 32'hC0);
    reg_wr(3'd2, 32'h1);
    src_en = 1'b1;
    wait_poll(120);
    chk(mem[24] == 32'hC0DE_0000 + 32'(s0), "R10 first word at original address", mem[24], 32'hC0DE_0000 + 32'(s0));
    chk(mem[25] == 32'hC0DE_0000 + 32'(s0 + 1), "R10 second word at original address", mem[25], 32'hC0DE_0000 + 32'(s0 + 1));
    chk(mem[48] == 32'h5A00_0030, "R10 second start address untouched", mem[48], 32'h5A00_0030);
    reg_rd(3'd4, d);
    chk(d == 32'h0012_0000, "R10 original transfer completes", d, 32'h0012_0000);

    chk(addr_bad == 0, "R3 high address on every request", 32'(addr_bad), 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule